// File: doc/BRIEF.md
# SPI Frame Sniffer with Command-Echo Decoder

This block watches a four-wire SPI link without taking part in it. The clock, both data lines and the select line are inputs only, so the block can never disturb the bus. While the select line sits at its configured active level, the block shifts in one MOSI bit and one MISO bit on each selected clock edge. When select returns to idle, the block turns the captured words into one record. The record holds the decoded fields, a millivolt value, a channel number, a start timestamp and a set of error flags.

The expected traffic is a fixed read exchange. The controller sends a 16-bit command twice. The peripheral returns a 12-bit conversion, four reserved bits, and an echo of the command. Frames that break this pattern are still reported, with flags that show what went wrong. A trigger pulse marks each frame that has the correct length, so that downstream logic can start or stop a recording. The bus signals are asynchronous to the system clock. They pass through two-flop synchronizers, so the system clock must run at least four times faster than the SPI clock.

Top module: `spi_frame_sniffer`

## Requirements
- R1: Bits are sampled only on the rising edge of the SPI clock when `sample_falling_i`=0, and only on the falling edge when it is 1. Bits arrive most significant first, so the first bit of a frame ends up in bit 31.
- R2: Select is active high when `cs_active_high_i`=1 and active low when it is 0. Clock edges seen while select is inactive change no record field and start no frame.
- R3: The first 16 MOSI bits appear on `rec_cmd_o` and the next 16 on `rec_rpt_o`. `err_mismatch_o` is set when the two differ.
- R4: `err_illegal_o` is set when `rec_cmd_o` is neither 0x428B nor 0x528B. `rec_chan_o` is 1 for 0x528B and 0 otherwise.
- R5: The MISO word splits into three fields: `rec_raw_o` takes bits 11:0, `rec_rsvd_o` takes bits 15:12 and `rec_echo_o` takes bits 31:16. `err_echo_o` is set when the echo differs from `rec_cmd_o`.
- R6: `rec_mv_o` equals twice `rec_raw_o`, with no offset.
- R7: `rec_len_o` reports the number of bits in the frame, saturating at 63. Any frame whose count is not 32 sets `err_len_o`. Data fields always hold the last 32 bits shifted in.
- R8: `trig_o` pulses for one cycle, together with `rec_valid_o`, for every frame of exactly 32 bits. It stays low for frames of any other length.
- R9: `rec_valid_o` is high for a single cycle per frame. All record outputs hold their values until the next frame ends.
- R10: `rec_ts_o` holds the value of a free-running system-clock counter, taken when select became active. The difference between two records' timestamps therefore equals the number of cycles between the two frame starts.
- R11: `rec_ovf_o` is set when a record is written while the previous one has not been acknowledged with `rec_ack_i`. An acknowledge in the same cycle as the new record counts as a read.
- R12: After reset, `rec_valid_o`, `trig_o`, `rec_ovf_o` and `rec_ts_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Monitored SPI clock |
| mosi_i | input | 1 | Monitored controller-to-peripheral data |
| miso_i | input | 1 | Monitored peripheral-to-controller data |
| cs_i | input | 1 | Monitored select line |
| cs_active_high_i | input | 1 | 1: select is active high |
| sample_falling_i | input | 1 | 1: sample on the falling clock edge |
| rec_ack_i | input | 1 | Marks the current record as read |
| rec_valid_o | output | 1 | One-cycle strobe for a new record |
| trig_o | output | 1 | Trigger for a well-formed frame |
| rec_cmd_o | output | 16 | First MOSI command |
| rec_rpt_o | output | 16 | Repeated MOSI command |
| rec_raw_o | output | 12 | Raw conversion result |
| rec_rsvd_o | output | 4 | Reserved MISO bits |
| rec_echo_o | output | 16 | Command echo from MISO |
| rec_mv_o | output | 13 | Result in millivolts |
| rec_chan_o | output | 1 | Decoded channel |
| rec_len_o | output | 6 | Bits captured in the frame |
| rec_ts_o | output | 32 | Timestamp of the frame start |
| err_len_o | output | 1 | Frame length is not 32 |
| err_mismatch_o | output | 1 | The two commands differ |
| err_illegal_o | output | 1 | Unknown command |
| err_echo_o | output | 1 | Echo differs from the command |
| rec_ovf_o | output | 1 | Previous record was lost unread |

## Verification
The acknowledge of the old record and the writing of a new one can fall in the same cycle. Overflow detection depends on how that collision is resolved. The bench first measures the fixed delay from select release to the record strobe. It then raises `rec_ack_i` for exactly the strobe cycle and expects `rec_ovf_o`=0. A following frame that is left unacknowledged must then show `rec_ovf_o`=1, which proves the new record was taken as unread.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  localparam logic [15:0] CMD_READ_CH0 = 16'h428B;
  localparam logic [15:0] CMD_READ_CH1 = 16'h528B;

  typedef struct packed {
    logic len;
    logic mismatch;
    logic illegal;
    logic echo;
  } frame_err_t;
endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/sniff_capture.sv
module sniff_capture #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned TS_W    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic               miso_i,
  input  logic               cs_i,
  input  logic               cs_active_high_i,
  input  logic               sample_falling_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] mosi_word_o,
  output logic [FRAME_W-1:0] miso_word_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [TS_W-1:0]    ts_o
);
  logic            sclk_q, act_q, act, start, take;
  logic [TS_W-1:0] tick_q;

  assign act   = cs_active_high_i ? cs_i : ~cs_i;
  assign start = act & ~act_q;
  assign done_o = ~act & act_q;
  assign take  = act & ~start &
                 (sample_falling_i ? (sclk_q & ~sclk_i) : (~sclk_q & sclk_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      tick_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      act_q  <= act;
      tick_q <= tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mosi_word_o <= '0;
      miso_word_o <= '0;
      bit_cnt_o   <= '0;
      ts_o        <= '0;
    end else if (start) begin
      mosi_word_o <= '0;
      miso_word_o <= '0;
      bit_cnt_o   <= '0;
      ts_o        <= tick_q;
    end else if (take) begin
      mosi_word_o <= {mosi_word_o[FRAME_W-2:0], mosi_i};
      miso_word_o <= {miso_word_o[FRAME_W-2:0], miso_i};
      if (bit_cnt_o != '1) bit_cnt_o <= bit_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/sniff_decode.sv
module sniff_decode
  import sniff_pkg::*;
#(
  parameter int unsigned CMD_W = 16,
  parameter int unsigned RAW_W = 12,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TS_W  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [2*CMD_W-1:0]   mosi_word_i,
  input  logic [2*CMD_W-1:0]   miso_word_i,
  input  logic [CNT_W-1:0]     bit_cnt_i,
  input  logic [TS_W-1:0]      ts_i,
  input  logic                 ack_i,
  output logic                 valid_o,
  output logic                 trig_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [CMD_W-1:0]     rpt_o,
  output logic [RAW_W-1:0]     raw_o,
  output logic [CMD_W-RAW_W-1:0] rsvd_o,
  output logic [CMD_W-1:0]     echo_o,
  output logic [RAW_W:0]       mv_o,
  output logic                 chan_o,
  output logic [CNT_W-1:0]     len_o,
  output logic [TS_W-1:0]      ts_o,
  output frame_err_t           err_o,
  output logic                 ovf_o
);
  localparam int unsigned FRAME_W = 2 * CMD_W;
  localparam int unsigned RSVD_W  = CMD_W - RAW_W;

  logic [CMD_W-1:0]  cmd, rpt, echo;
  logic [RAW_W-1:0]  raw;
  logic [RSVD_W-1:0] rsvd;
  frame_err_t        err;
  logic              unread_q;

  assign cmd  = mosi_word_i[FRAME_W-1 -: CMD_W];
  assign rpt  = mosi_word_i[CMD_W-1:0];
  assign echo = miso_word_i[FRAME_W-1 -: CMD_W];
  assign rsvd = miso_word_i[CMD_W-1 -: RSVD_W];
  assign raw  = miso_word_i[RAW_W-1:0];

  always_comb begin
    err.len      = bit_cnt_i != CNT_W'(FRAME_W);
    err.mismatch = cmd != rpt;
    err.illegal  = (cmd != CMD_W'(CMD_READ_CH0)) && (cmd != CMD_W'(CMD_READ_CH1));
    err.echo     = echo != cmd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      trig_o   <= 1'b0;
      unread_q <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= done_i;
      trig_o  <= done_i & ~err.len;
      if (done_i) begin
        ovf_o    <= unread_q & ~ack_i;
        unread_q <= 1'b1;
      end else if (ack_i) begin
        unread_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= '0;
      rpt_o  <= '0;
      raw_o  <= '0;
      rsvd_o <= '0;
      echo_o <= '0;
      mv_o   <= '0;
      chan_o <= 1'b0;
      len_o  <= '0;
      ts_o   <= '0;
      err_o  <= '0;
    end else if (done_i) begin
      cmd_o  <= cmd;
      rpt_o  <= rpt;
      raw_o  <= raw;
      rsvd_o <= rsvd;
      echo_o <= echo;
      mv_o   <= {raw, 1'b0};
      chan_o <= cmd == CMD_W'(CMD_READ_CH1);
      len_o  <= bit_cnt_i;
      ts_o   <= ts_i;
      err_o  <= err;
    end
  end
endmodule

// File: rtl/spi_frame_sniffer.sv
module spi_frame_sniffer
  import sniff_pkg::*;
#(
  parameter int unsigned CMD_W = 16,
  parameter int unsigned RAW_W = 12,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TS_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   mosi_i,
  input  logic                   miso_i,
  input  logic                   cs_i,
  input  logic                   cs_active_high_i,
  input  logic                   sample_falling_i,
  input  logic                   rec_ack_i,
  output logic                   rec_valid_o,
  output logic                   trig_o,
  output logic [CMD_W-1:0]       rec_cmd_o,
  output logic [CMD_W-1:0]       rec_rpt_o,
  output logic [RAW_W-1:0]       rec_raw_o,
  output logic [CMD_W-RAW_W-1:0] rec_rsvd_o,
  output logic [CMD_W-1:0]       rec_echo_o,
  output logic [RAW_W:0]         rec_mv_o,
  output logic                   rec_chan_o,
  output logic [CNT_W-1:0]       rec_len_o,
  output logic [TS_W-1:0]        rec_ts_o,
  output logic                   err_len_o,
  output logic                   err_mismatch_o,
  output logic                   err_illegal_o,
  output logic                   err_echo_o,
  output logic                   rec_ovf_o
);
  localparam int unsigned FRAME_W = 2 * CMD_W;

  logic [3:0]         bus_s;
  logic               done;
  logic [FRAME_W-1:0] mosi_word, miso_word;
  logic [CNT_W-1:0]   bit_cnt;
  logic [TS_W-1:0]    ts_start;
  frame_err_t         err;

  sniff_sync #(.W(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, miso_i, mosi_i, sclk_i}),
    .q_o    (bus_s)
  );

  sniff_capture #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_cap (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sclk_i           (bus_s[0]),
    .mosi_i           (bus_s[1]),
    .miso_i           (bus_s[2]),
    .cs_i             (bus_s[3]),
    .cs_active_high_i (cs_active_high_i),
    .sample_falling_i (sample_falling_i),
    .done_o           (done),
    .mosi_word_o      (mosi_word),
    .miso_word_o      (miso_word),
    .bit_cnt_o        (bit_cnt),
    .ts_o             (ts_start)
  );

  sniff_decode #(.CMD_W(CMD_W), .RAW_W(RAW_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .mosi_word_i (mosi_word),
    .miso_word_i (miso_word),
    .bit_cnt_i   (bit_cnt),
    .ts_i        (ts_start),
    .ack_i       (rec_ack_i),
    .valid_o     (rec_valid_o),
    .trig_o      (trig_o),
    .cmd_o       (rec_cmd_o),
    .rpt_o       (rec_rpt_o),
    .raw_o       (rec_raw_o),
    .rsvd_o      (rec_rsvd_o),
    .echo_o      (rec_echo_o),
    .mv_o        (rec_mv_o),
    .chan_o      (rec_chan_o),
    .len_o       (rec_len_o),
    .ts_o        (rec_ts_o),
    .err_o       (err),
    .ovf_o       (rec_ovf_o)
  );

  assign err_len_o      = err.len;
  assign err_mismatch_o = err.mismatch;
  assign err_illegal_o  = err.illegal;
  assign err_echo_o     = err.echo;
endmodule

// File: rtl/sniff_checker.sv
module sniff_checker #(
  parameter int unsigned CMD_W = 16,
  parameter int unsigned RAW_W = 12,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_o,
  input logic             trig_o,
  input logic             err_len_o,
  input logic             err_illegal_o,
  input logic             rec_chan_o,
  input logic [CNT_W-1:0] rec_len_o,
  input logic [RAW_W-1:0] rec_raw_o,
  input logic [RAW_W:0]   rec_mv_o,
  input logic [CMD_W-1:0] rec_cmd_o
);
  p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  p_hold_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> ($stable(rec_cmd_o) && $stable(rec_raw_o) && $stable(rec_len_o)));

  p_trig_good_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (rec_valid_o && !err_len_o && rec_len_o == CNT_W'(2*CMD_W)));

  p_len_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (err_len_o == (rec_len_o != CNT_W'(2*CMD_W))));

  p_millivolt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_mv_o == (RAW_W+1)'(rec_raw_o) * 2));

  p_channel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !err_illegal_o) |-> (rec_chan_o == (rec_cmd_o == 16'h528B)));
endmodule

bind spi_frame_sniffer sniff_checker #(.CMD_W(CMD_W), .RAW_W(RAW_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_spi_frame_sniffer.sv
`timescale 1ns/1ps
module sim_spi_frame_sniffer;
  localparam int H = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, miso = 0, cs = 1, pol = 0, fall = 0, ack = 0;
  logic        v, trig, chan, elen, emis, eill, eecho, ovf;
  logic [15:0] cmd, rpt, echo;
  logic [11:0] raw;
  logic [3:0]  rsvd;
  logic [12:0] mv;
  logic [5:0]  len;
  logic [31:0] ts;

  int checks = 0, fails = 0, lat = 0;
  longint cyc = 0, act_cyc = 0, prev_act = 0;
  logic [31:0] prev_ts = 0;
  bit have_prev = 0, done = 0;

  logic s_v, s_trig, s_chan, s_elen, s_emis, s_eill, s_eecho, s_ovf;
  logic [15:0] s_cmd, s_rpt, s_echo;
  logic [11:0] s_raw;
  logic [3:0]  s_rsvd;
  logic [12:0] s_mv;
  logic [5:0]  s_len;
  logic [31:0] s_ts;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_frame_sniffer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .miso_i(miso), .cs_i(cs),
    .cs_active_high_i(pol), .sample_falling_i(fall), .rec_ack_i(ack),
    .rec_valid_o(v), .trig_o(trig), .rec_cmd_o(cmd), .rec_rpt_o(rpt), .rec_raw_o(raw),
    .rec_rsvd_o(rsvd), .rec_echo_o(echo), .rec_mv_o(mv), .rec_chan_o(chan), .rec_len_o(len),
    .rec_ts_o(ts), .err_len_o(elen), .err_mismatch_o(emis), .err_illegal_o(eill),
    .err_echo_o(eecho), .rec_ovf_o(ovf)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic send_frame(input logic [63:0] mo, input logic [63:0] mi, input int n);
    @(negedge clk);
    cs = pol; act_cyc = cyc;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = mo[i]; miso = mi[i];
      repeat (H) @(negedge clk);
      sclk = ~sclk;
      @(negedge clk);
      mosi = ~mo[i]; miso = ~mi[i];
      repeat (H - 1) @(negedge clk);
      sclk = ~sclk;
    end
    repeat (H) @(negedge clk);
    cs = ~pol;
  endtask

  task automatic snap();
    s_v = v; s_trig = trig; s_chan = chan; s_elen = elen; s_emis = emis; s_eill = eill;
    s_eecho = eecho; s_ovf = ovf; s_cmd = cmd; s_rpt = rpt; s_echo = echo; s_raw = raw;
    s_rsvd = rsvd; s_mv = mv; s_len = len; s_ts = ts;
  endtask

  task automatic get_rec(output int n);
    n = 0;
    while (!v && n < 80) begin
      @(negedge clk);
      n++;
    end
    snap();
    chk("R9 record strobe seen", s_v, 1);
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic set_cfg(input logic p, input logic f);
    @(negedge clk);
    pol = p; fall = f; cs = ~p; sclk = f;
    repeat (10) @(negedge clk);
    pulse_ack();
    have_prev = 0;
  endtask

  task automatic check_full(input logic [15:0] c, input logic [15:0] r, input logic [15:0] e,
                            input logic [3:0] rs, input logic [11:0] rw, input logic exp_ovf);
    chk("R1/R3 command", s_cmd, c);
    chk("R3 repeat", s_rpt, r);
    chk("R3 mismatch flag", s_emis, c != r);
    chk("R4 illegal flag", s_eill, (c != 16'h428B) && (c != 16'h528B));
    chk("R4 channel", s_chan, c == 16'h528B);
    chk("R5 raw", s_raw, rw);
    chk("R5 reserved", s_rsvd, rs);
    chk("R5 echo", s_echo, e);
    chk("R5 echo flag", s_eecho, e != c);
    chk("R6 millivolts", s_mv, 2 * rw);
    chk("R7 length", s_len, 32);
    chk("R7 length flag", s_elen, 0);
    chk("R8 trigger", s_trig, 1);
    chk("R11 overflow", s_ovf, exp_ovf);
    if (have_prev) chk("R10 timestamp delta", s_ts - prev_ts, act_cyc - prev_act);
    prev_ts = s_ts; prev_act = act_cyc; have_prev = 1;
  endtask

  task automatic good_frame(input logic [15:0] c, input logic [15:0] r, input logic [15:0] e,
                            input logic [3:0] rs, input logic [11:0] rw);
    int n;
    send_frame({32'h0, c, r}, {32'h0, e, rs, rw}, 32);
    get_rec(n);
    lat = n;
    check_full(c, r, e, rs, rw, 0);
    pulse_ack();
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 valid after reset", v, 0);
    chk("R12 trigger after reset", trig, 0);
    chk("R12 overflow after reset", ovf, 0);
    chk("R12 timestamp after reset", ts, 0);

    set_cfg(0, 0);
    good_frame(16'h428B, 16'h428B, 16'h428B, 4'h0, 12'hABC);
    good_frame(16'h528B, 16'h528B, 16'h528B, 4'hF, 12'hFFF);

    // R2: clock activity with select idle must not disturb the next record
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); mosi = k[0]; miso = ~k[0]; sclk = ~sclk;
      repeat (H) @(negedge clk);
    end
    sclk = 0;
    repeat (H) @(negedge clk);
    good_frame(16'h528B, 16'h528B, 16'h528B, 4'h5, 12'h001);

    set_cfg(1, 1);
    good_frame(16'h428B, 16'h428B, 16'h428B, 4'hA, 12'h555);
    good_frame(16'h1234, 16'h1235, 16'h9999, 4'h3, 12'h000);

    // R7/R8: short, empty and long frames
    begin
      int n;
      send_frame(64'h0, 64'h0, 20);
      get_rec(n);
      chk("R7 short length", s_len, 20);
      chk("R7 short flag", s_elen, 1);
      chk("R8 short no trigger", s_trig, 0);
      pulse_ack();
      send_frame(64'h0, 64'h0, 0);
      get_rec(n);
      chk("R7 empty length", s_len, 0);
      chk("R8 empty no trigger", s_trig, 0);
      pulse_ack();
      send_frame({24'h0, 8'hFF, 32'h428B428B}, {24'h0, 8'h00, 32'h428B0123}, 40);
      get_rec(n);
      chk("R7 long length", s_len, 40);
      chk("R7 long flag", s_elen, 1);
      chk("R7 long keeps last bits", s_cmd, 16'h428B);
      chk("R8 long no trigger", s_trig, 0);
      pulse_ack();
    end

    // R11: acknowledge in the strobe cycle, then an unacknowledged pair
    begin
      int n;
      send_frame({32'h0, 32'h428B428B}, {32'h0, 32'h428B0010}, 32);
      get_rec(n);
      chk("R11 first no overflow", s_ovf, 0);
      send_frame({32'h0, 32'h528B528B}, {32'h0, 32'h528B0020}, 32);
      repeat (lat - 1) @(negedge clk);
      ack = 1;
      @(negedge clk);
      snap();
      ack = 0;
      chk("R9 strobe at measured latency", s_v, 1);
      chk("R11 same-cycle ack is a read", s_ovf, 0);
      send_frame({32'h0, 32'h428B428B}, {32'h0, 32'h428B0030}, 32);
      get_rec(n);
      chk("R11 unread overwritten", s_ovf, 1);
      @(negedge clk);
      chk("R9 strobe is one cycle", v, 0);
      chk("R9 fields held", raw, 12'h030);
      pulse_ack();
      have_prev = 0;
    end

    // random traffic
    for (int k = 0; k < 24; k++) begin
      logic [15:0] c, r, e;
      logic [3:0]  rs;
      logic [11:0] rw;
      if (k % 8 == 0) set_cfg($urandom % 2, $urandom % 2);
      case ($urandom % 3)
        0: c = 16'h428B;
        1: c = 16'h528B;
        default: c = 16'($urandom);
      endcase
      r  = ($urandom % 5 == 0) ? 16'($urandom) : c;
      e  = ($urandom % 5 == 0) ? 16'($urandom) : c;
      rs = 4'($urandom);
      rw = 12'($urandom);
      good_frame(c, r, e, rs, rw);
    end

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end
endmodule